// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus controller access to a 64 K byte-wide register space through a 16-bit register pointer. A fast system clock samples SCL and SDA through synchronizers. The block finds start, repeated start and stop conditions on the synchronized lines and answers one fixed 7-bit device address. It drives SDA only as an open-drain enable, and it never stretches the clock.

A write transfer carries the device address with direction bit 0. The next two bytes load the pointer, high byte first. Every byte after that is written to the register port at the pointer, and the pointer then advances. A read transfer carries direction bit 1 and returns bytes straight from the current pointer. The pointer keeps its value between transfers, so a write that only sets the pointer, followed by a repeated start and a read, reads from that location.

The register port is synchronous. Write address, data and strobe are registered. A read strobe asks for the byte at the address, and that byte must be on the read-data input on the clock after the strobe, as a block RAM provides it.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is high and after it is released with no bus activity, `sda_oe` is 0 and `reg_we` and `reg_re` are 0.
- R2: The first byte after a start is a 7-bit device address, MSB first, then a direction bit (0 = write to the target, 1 = read from it). When the address equals `DEV_ADDR`, the target pulls SDA low during the ninth SCL pulse.
- R3: When the address differs, SDA stays released in the ninth pulse and for all later bytes. The target performs no register access and leaves the pointer unchanged until the next start.
- R4: In a write transfer the two bytes after the address byte set the pointer (high byte first). Each later byte produces one `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, and the target acknowledges every byte it receives.
- R5: The pointer increments by one after each data byte written or read, and it wraps from 0xFFFF to 0x0000.
- R6: In a read transfer, data bytes follow the address byte directly. They come from the current pointer, are sent MSB first, and continue across transfers from where the pointer stands.
- R7: When the controller leaves SDA high in the ninth pulse of a byte the target sent, the target releases SDA and ignores further SCL pulses until the next start.
- R8: A start or stop may arrive at any point. A partly received byte is then dropped with no write and no pointer change, and a repeated start can take the place of a stop.
- R9: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R10: `reg_we` and `reg_re` are single-cycle pulses and are never high together. Read data is sampled on the clock after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr | output | 16 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid the clock after `reg_re` |

## Verification
A corrupt pointer shows up at once in the next `reg_we` address. On a read it shows up in the first data bit, which is sampled on the following SCL high phase. A wrong sequencer state shows up within one byte time as an acknowledge in the wrong ninth pulse, a missing acknowledge, or SDA driven after a not-acknowledge. A stale or missing read fetch puts a wrong bit on SDA in the first data pulse of the affected byte. The bench compares every write strobe against an expected queue on the clock it occurs, so a wrong write is reported on the same cycle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PHI, ST_PLO, ST_WDATA, ST_ACKO, ST_TX, ST_ACKI
  } tgt_state_t;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - 8;

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (ld_hi) ptr[ADDR_W-1:8] <= din[HI_W-1:0];
    else if (ld_lo) ptr[7:0] <= din;
    else if (inc)   ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_t state, after_ack;
  logic [BYTE_W-1:0] sr, rbuf;
  logic [CNT_W-1:0]  bitcnt;
  logic nack, fetch_pend, rd_cap, byte_done;
  logic ld_hi, ld_lo, ptr_inc;
  logic [ADDR_W-1:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = scl_fall && (bitcnt == LAST_BIT) && !start_det && !stop_det;
  assign ld_hi   = byte_done && (state == ST_PHI);
  assign ld_lo   = byte_done && (state == ST_PLO);
  assign ptr_inc = byte_done && ((state == ST_WDATA) || (state == ST_TX));

  i2c_reg_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(ptr_inc),
    .din(sr), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      after_ack  <= ST_IDLE;
      sr         <= '0;
      rbuf       <= '0;
      bitcnt     <= '0;
      nack       <= 1'b0;
      fetch_pend <= 1'b0;
      rd_cap     <= 1'b0;
      sda_oe     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_we     <= 1'b0;
      reg_re     <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      rd_cap <= reg_re;
      if (rd_cap) rbuf <= reg_rdata;
      if (fetch_pend) begin
        reg_re     <= 1'b1;
        reg_addr   <= ptr;
        fetch_pend <= 1'b0;
      end
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PHI, ST_PLO, ST_WDATA: begin
            if (scl_rise) begin
              sr     <= {sr[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_ADDR && sr[7:1] != DEV_ADDR) begin
                state <= ST_IDLE;
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACKO;
                if (state == ST_ADDR) begin
                  after_ack <= sr[0] ? ST_TX : ST_PHI;
                  if (sr[0]) fetch_pend <= 1'b1;
                end else if (state == ST_PHI) begin
                  after_ack <= ST_PLO;
                end else begin
                  after_ack <= ST_WDATA;
                  if (state == ST_WDATA) begin
                    reg_we    <= 1'b1;
                    reg_wdata <= sr;
                    reg_addr  <= ptr;
                  end
                end
              end
            end
          end
          ST_ACKO: begin
            if (scl_fall) begin
              state  <= after_ack;
              bitcnt <= '0;
              if (after_ack == ST_TX) begin
                sr     <= rbuf;
                sda_oe <= ~rbuf[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              sda_oe     <= 1'b0;
              state      <= ST_ACKI;
              fetch_pend <= 1'b1;
            end else if (scl_fall) begin
              sr     <= {sr[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sr[BYTE_W-2];
            end
          end
          ST_ACKI: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                sr     <= rbuf;
                sda_oe <= ~rbuf[BYTE_W-1];
                bitcnt <= '0;
                state  <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  assert_we_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_re_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);

  assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  assert_we_with_ack_R4: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $rose(sda_oe));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int r9_viol = 0, r10_viol = 0;
  int exp_ptr = 0;
  int qa[$], qd[$];
  bit [7:0] mem [int];
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV)) i_i2c_reg_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  function automatic bit [7:0] mval(int a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // register model and per-clock comparison
  always @(posedge clk) begin
    if (!rst) begin
      if (reg_re) reg_rdata <= mval(int'(reg_addr));
      if (reg_we && reg_re) r10_viol++;
      if (sda_oe !== oe_prev && scl_m) r9_viol++;
      oe_prev <= sda_oe;
      if (reg_we) begin
        n_chk++;
        if (qa.size() == 0) begin
          n_fail++;
          $display("FAIL R3/R8 unexpected write: actual %0h expected none", reg_addr);
        end else begin
          int ea, ed;
          ea = qa.pop_front();
          ed = qd.pop_front();
          if (int'(reg_addr) != ea || int'(reg_wdata) != ed) begin
            n_fail++;
            $display("FAIL R4 write: actual %0h/%0h expected %0h/%0h",
                     reg_addr, reg_wdata, ea, ed);
          end
        end
        mem[int'(reg_addr)] = reg_wdata;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic m_bit(input bit b, output bit s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_wbyte(input bit [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic m_rbyte(input bit give_ack, output bit [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      d[i] = s;
    end
    m_bit(!give_ack, s);
  endtask

  task automatic set_ptr(int p);
    bit ack;
    m_start();
    m_wbyte({DEV, 1'b0}, ack); chk(ack, "R2 write address ack", ack, 1);
    m_wbyte(p[15:8], ack);     chk(ack, "R4 pointer high ack", ack, 1);
    m_wbyte(p[7:0], ack);      chk(ack, "R4 pointer low ack", ack, 1);
    exp_ptr = p;
  endtask

  task automatic wr_data(int n, int d0);
    bit ack;
    for (int k = 0; k < n; k++) begin
      qa.push_back(exp_ptr);
      qd.push_back((d0 + k) & 8'hFF);
      m_wbyte(8'((d0 + k) & 8'hFF), ack);
      chk(ack, "R4 data ack", ack, 1);
      exp_ptr = (exp_ptr + 1) & 16'hFFFF;
    end
  endtask

  task automatic rd_data(int n, string tag);
    bit ack;
    bit [7:0] d;
    m_start();
    m_wbyte({DEV, 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      m_rbyte(k != n - 1, d);
      chk(d == mval(exp_ptr), tag, d, mval(exp_ptr));
      exp_ptr = (exp_ptr + 1) & 16'hFFFF;
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    bit ack, s;
    tick(5);
    chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R1 reset outputs",
        {sda_oe, reg_we, reg_re}, 0);
    rst = 1'b0;
    tick(20);
    chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R1 idle outputs",
        {sda_oe, reg_we, reg_re}, 0);

    // R4: pointer load then three writes
    set_ptr(16'h1234); wr_data(3, 8'h10); m_stop();

    // R6 and R8: pointer-only write, repeated start, read
    set_ptr(16'h2000);
    rd_data(3, "R6 read after repeated start (R8)"); m_stop();
    // R6: next transfer continues from the pointer
    rd_data(2, "R6 pointer kept across transfers"); m_stop();
    chk(exp_ptr == 16'h2005, "R6 bench pointer", exp_ptr, 16'h2005);

    // R5: wrap from 0xFFFF to 0x0000
    set_ptr(16'hFFFF); wr_data(2, 8'hC0); m_stop();
    chk(mem.exists(0) && mem[0] == 8'hC1, "R5 wrap write at 0000", mval(0), 8'hC1);
    rd_data(1, "R5 read after wrap at 0001"); m_stop();

    // R4: written data read back
    set_ptr(16'h1234);
    rd_data(3, "R4 read back of written bytes"); m_stop();

    // R3: wrong device address
    m_start();
    m_wbyte({DEV ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R3 wrong address not acknowledged", ack, 0);
    for (int k = 0; k < 3; k++) begin
      m_wbyte(8'h00, ack);
      chk(!ack, "R3 following bytes ignored", ack, 0);
    end
    m_stop();
    rd_data(1, "R3 pointer unchanged"); m_stop();

    // R8: partial byte dropped by stop
    set_ptr(16'h3000);
    for (int k = 0; k < 4; k++) m_bit(1'b0, s);
    m_stop();
    exp_ptr = 16'h3000;
    rd_data(1, "R8 partial byte not written"); m_stop();

    // R8: start replaces stop after a write
    set_ptr(16'h4000); wr_data(1, 8'h77);
    rd_data(1, "R8 start in place of stop"); m_stop();

    // R7: NACK ends the read, further pulses ignored
    rd_data(1, "R7 byte before not-acknowledge");
    for (int k = 0; k < 9; k++) begin
      m_bit(1'b1, s);
      chk(s == 1'b1, "R7 SDA released after not-acknowledge", s, 1);
    end
    m_stop();
    chk(sda_oe == 1'b0, "R7 released at idle", sda_oe, 0);
    rd_data(1, "R7 pointer after not-acknowledge"); m_stop();

    tick(10);
    chk(r9_viol == 0, "R9 SDA enable changed while SCL high", r9_viol, 0);
    chk(r10_viol == 0, "R10 both strobes together", r10_viol, 0);
    chk(qa.size() == 0, "R4 expected writes all seen", qa.size(), 0);
    report();
  end
endmodule